// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings a DRAM into service and then keeps its contents alive. After a synchronous reset it waits through a programmable power-up pause. It then issues a fixed number of wake-up RAS cycles, driving the strobes itself because no access can be in flight yet. Only after that does it raise its ready flag, and the access controller must not accept work before then.

Once ready, a free-running interval timer produces one refresh request per slot. Each slot is the retention window divided by the number of rows: 512 refreshes in every 8 ms, so about 15.6 µs, or 780 clocks at 50 MHz. For each request the sequencer raises a request line and waits for a grant from the access controller. It then overrides the strobes with a CAS-before-RAS cycle: CAS goes low first, RAS falls while CAS is held low, and both return high for the precharge time. It then pulses a completion flag. The device's own row counter supplies the row, so no address is driven and the data pins stay undriven.

A request can go unanswered until the next slot arrives. When that happens the retention budget is considered broken: an overrun flag rises and ready drops. On the next grant the sequencer repeats the full set of wake-up cycles before it declares ready again.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high, ready, ref_req, ref_done, overrun and strobe_own are 0, and ras_n and cas_n are 1.
- R2: Neither strobe goes low during the first PAUSE_CLKS clocks after reset is released.
- R3: Exactly WAKE_CYCLES RAS low pulses occur between reset release and the first rise of ready. Ready cannot rise earlier than PAUSE_CLKS + WAKE_CYCLES × (CAS_LEAD_CLKS + RAS_LOW_CLKS + RAS_PRE_CLKS) clocks after reset release.
- R4: At every falling edge of ras_n, cas_n is already low (CAS-before-RAS order).
- R5: Each ras_n low pulse lasts exactly RAS_LOW_CLKS clocks. ras_n stays high for at least RAS_PRE_CLKS clocks between consecutive low pulses.
- R6: After ready, and with grants given promptly, ref_req rises exactly every REF_INTERVAL_CLKS clocks. Each granted request produces one RAS pulse.
- R7: While ref_req is high, ras_n and cas_n remain high. A strobe cycle starts only after a grant.
- R8: Each granted refresh ends with a single-cycle ref_done pulse, during which ras_n and cas_n are both high.
- R9: If a new interval elapses while a request is still ungranted, overrun goes to 1 and ready goes to 0. ref_req stays high.
- R10: After an overrun, the next grant triggers exactly WAKE_CYCLES RAS pulses. Ready then returns to 1 and overrun to 0.
- R11: strobe_own is 1 in every cycle in which ras_n or cas_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant | input | 1 | Grant from the access controller for a pending request |
| ready | output | 1 | DRAM initialised and refresh on schedule |
| ref_req | output | 1 | Refresh slot pending, asking for the strobes |
| ref_done | output | 1 | One-cycle pulse when a granted refresh completes |
| overrun | output | 1 | A refresh slot was missed; cleared after re-initialisation |
| strobe_own | output | 1 | Sequencer is driving the strobes; the controller must release them |
| ras_n | output | 1 | Row strobe override, active low |
| cas_n | output | 1 | Column strobe override, active low (both byte strobes) |

## Verification
The assertions assume the recovery wake-up burst is shorter than one refresh interval. This keeps a second tick from arriving within a single recovery. The bench configuration uses a 64-clock interval against a 48-clock burst to stay inside that assumption. They also assume ref_grant is only meaningful while ref_req is high. The bench derives grant from ref_req one clock after the request, and it withholds grant for well over one interval only when it deliberately provokes an overrun.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    S_PAUSE,
    S_WAKE,
    S_IDLE,
    S_REQ,
    S_REF
  } seq_state_t;

  typedef enum logic [1:0] {
    P_IDLE,
    P_LEAD,
    P_LOW,
    P_PRE
  } strobe_phase_t;

endpackage

// File: rtl/period_timer.sv
module period_timer #(
  parameter int LIMIT = 780
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q == W'(LIMIT - 1));
  assign tick   = en && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cbr_strobe_gen.sv
module cbr_strobe_gen
  import dram_refresh_pkg::*;
#(
  parameter int CAS_LEAD_CLKS = 1,
  parameter int RAS_LOW_CLKS  = 3,
  parameter int RAS_PRE_CLKS  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done,
  output logic own,
  output logic ras_n,
  output logic cas_n
);
  localparam int MAX_AB = (CAS_LEAD_CLKS > RAS_LOW_CLKS) ? CAS_LEAD_CLKS : RAS_LOW_CLKS;
  localparam int MAX_P  = (MAX_AB > RAS_PRE_CLKS) ? MAX_AB : RAS_PRE_CLKS;
  localparam int CW     = $clog2(MAX_P + 1);

  strobe_phase_t phase_q;
  logic [CW-1:0] cnt_q;
  logic          done_q, own_q, ras_q, cas_q;

  assign busy  = (phase_q != P_IDLE);
  assign done  = done_q;
  assign own   = own_q;
  assign ras_n = ras_q;
  assign cas_n = cas_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= P_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      own_q   <= 1'b0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        P_IDLE: begin
          if (start) begin
            phase_q <= P_LEAD;
            cnt_q   <= '0;
            cas_q   <= 1'b0;
            own_q   <= 1'b1;
          end
        end
        P_LEAD: begin
          if (cnt_q == CW'(CAS_LEAD_CLKS - 1)) begin
            phase_q <= P_LOW;
            cnt_q   <= '0;
            ras_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        P_LOW: begin
          if (cnt_q == CW'(RAS_LOW_CLKS - 1)) begin
            phase_q <= P_PRE;
            cnt_q   <= '0;
            ras_q   <= 1'b1;
            cas_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == CW'(RAS_PRE_CLKS - 1)) begin
            phase_q <= P_IDLE;
            cnt_q   <= '0;
            own_q   <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // width monitor for the RAS low pulse, used by the checks below
  logic [CW-1:0] low_len_q;
  always_ff @(posedge clk) begin
    if (rst || ras_q) low_len_q <= '0;
    else              low_len_q <= low_len_q + 1'b1;
  end

  a_r4_cbr_order: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> !cas_n);

  a_r5_ras_width: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (low_len_q == CW'(RAS_LOW_CLKS)));

  a_r11_own_covers: assert property (@(posedge clk) disable iff (rst)
    (!ras_n || !cas_n) |-> own);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (ras_n && cas_n));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CLKS        = 10000,
  parameter int WAKE_CYCLES       = 8,
  parameter int REF_INTERVAL_CLKS = 780,
  parameter int CAS_LEAD_CLKS     = 1,
  parameter int RAS_LOW_CLKS      = 3,
  parameter int RAS_PRE_CLKS      = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_grant,
  output logic ready,
  output logic ref_req,
  output logic ref_done,
  output logic overrun,
  output logic strobe_own,
  output logic ras_n,
  output logic cas_n
);
  localparam int WCW = $clog2(WAKE_CYCLES + 1);

  seq_state_t     state_q;
  logic [WCW-1:0] wake_cnt_q;
  logic           pend_q, init_done_q, ready_q, overrun_q, done_q;
  logic           pause_tick, int_tick;
  logic           sg_start, sg_busy, sg_done;
  logic           last_wake, wake_finish, grant_take, miss;

  period_timer #(.LIMIT(PAUSE_CLKS)) u_pause (
    .clk (clk),
    .rst (rst),
    .en  (state_q == S_PAUSE),
    .tick(pause_tick)
  );

  period_timer #(.LIMIT(REF_INTERVAL_CLKS)) u_interval (
    .clk (clk),
    .rst (rst),
    .en  (init_done_q),
    .tick(int_tick)
  );

  cbr_strobe_gen #(
    .CAS_LEAD_CLKS(CAS_LEAD_CLKS),
    .RAS_LOW_CLKS (RAS_LOW_CLKS),
    .RAS_PRE_CLKS (RAS_PRE_CLKS)
  ) u_strobe (
    .clk  (clk),
    .rst  (rst),
    .start(sg_start),
    .busy (sg_busy),
    .done (sg_done),
    .own  (strobe_own),
    .ras_n(ras_n),
    .cas_n(cas_n)
  );

  always_comb begin
    last_wake   = (wake_cnt_q == WCW'(WAKE_CYCLES - 1));
    wake_finish = (state_q == S_WAKE) && sg_done && last_wake;
    grant_take  = (state_q == S_REQ) && ref_grant;
    miss        = int_tick && pend_q && !grant_take && (state_q != S_WAKE);
    sg_start    = !sg_busy &&
                  (((state_q == S_WAKE) && !wake_finish) ||
                   (grant_take && !overrun_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_PAUSE;
      wake_cnt_q  <= '0;
      pend_q      <= 1'b0;
      init_done_q <= 1'b0;
      ready_q     <= 1'b0;
      overrun_q   <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_PAUSE: begin
          if (pause_tick) begin
            state_q    <= S_WAKE;
            wake_cnt_q <= '0;
          end
        end
        S_WAKE: begin
          if (sg_done) begin
            if (last_wake) begin
              state_q     <= S_IDLE;
              init_done_q <= 1'b1;
            end else begin
              wake_cnt_q <= wake_cnt_q + 1'b1;
            end
          end
        end
        S_IDLE: begin
          if (pend_q) state_q <= S_REQ;
        end
        S_REQ: begin
          if (ref_grant) begin
            state_q    <= overrun_q ? S_WAKE : S_REF;
            wake_cnt_q <= '0;
          end
        end
        default: begin
          if (sg_done) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end
        end
      endcase

      if (int_tick)        pend_q <= 1'b1;
      else if (grant_take) pend_q <= 1'b0;

      if (wake_finish) begin
        ready_q   <= 1'b1;
        overrun_q <= 1'b0;
      end else if (miss) begin
        ready_q   <= 1'b0;
        overrun_q <= 1'b1;
      end
    end
  end

  assign ready    = ready_q;
  assign ref_req  = (state_q == S_REQ);
  assign ref_done = done_q;
  assign overrun  = overrun_q;

  a_r7_hold_without_grant: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_grant) |=> (ras_n && cas_n));

  a_r9_not_ready_in_overrun: assert property (@(posedge clk) disable iff (rst)
    overrun |-> !ready);

  a_r10_ready_after_recovery: assert property (@(posedge clk) disable iff (rst)
    $fell(overrun) |-> ready);

  a_r2_quiet_pause: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_PAUSE) |-> (ras_n && cas_n && !ready));

endmodule

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int PAUSE = 20;
  localparam int WAKE  = 8;
  localparam int INTV  = 64;
  localparam int LEAD  = 1;
  localparam int LOW   = 3;
  localparam int PRE   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_grant = 1'b0;
  logic ready, ref_req, ref_done, overrun, strobe_own, ras_n, cas_n;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CLKS(PAUSE), .WAKE_CYCLES(WAKE), .REF_INTERVAL_CLKS(INTV),
    .CAS_LEAD_CLKS(LEAD), .RAS_LOW_CLKS(LOW), .RAS_PRE_CLKS(PRE)
  ) uut (
    .clk(clk), .rst(rst), .ref_grant(ref_grant), .ready(ready),
    .ref_req(ref_req), .ref_done(ref_done), .overrun(overrun),
    .strobe_own(strobe_own), .ras_n(ras_n), .cas_n(cas_n)
  );

  int total = 0;
  int bad = 0;
  bit fin = 0;
  bit allow = 0;
  bit gap_mode = 0;

  int cyc = 0, falls = 0, low_len = 0, high_len = 0;
  int first_cas = -1, ready_rise = -1, last_req = -1, req_rises = 0, done_cnt = 0;
  bit seen_fall = 0;
  logic p_ras = 1, p_cas = 1, p_ready = 0, p_req = 0, p_done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      ref_grant = allow && ref_req;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        check(!ready && !ref_req && !ref_done && !overrun && !strobe_own && ras_n && cas_n,
              "R1 reset outputs", {ready, ref_req, ref_done, overrun, strobe_own, ras_n, cas_n},
              7'b0000011);
      end else begin
        cyc++;
        if (p_ras && !ras_n) begin
          falls++;
          check(cas_n == 1'b0, "R4 cas low at ras fall", cas_n, 0);
          if (seen_fall) check(high_len >= PRE, "R5 precharge", high_len, PRE);
          seen_fall = 1;
        end
        if (!p_ras && ras_n) check(low_len == LOW, "R5 ras width", low_len, LOW);
        if (!ras_n) begin low_len++; high_len = 0; end
        else begin high_len++; low_len = 0; end
        if (p_cas && !cas_n && first_cas < 0) first_cas = cyc;
        if (!ras_n || !cas_n) check(strobe_own, "R11 own", strobe_own, 1);
        if (ref_req) check(ras_n && cas_n, "R7 strobes idle while requesting", {ras_n, cas_n}, 3);
        if (!p_ready && ready && ready_rise < 0) ready_rise = cyc;
        if (!p_req && ref_req) begin
          if (gap_mode && last_req >= 0) check(cyc - last_req == INTV, "R6 request spacing", cyc - last_req, INTV);
          last_req = cyc;
          req_rises++;
        end
        if (ref_done) begin
          done_cnt++;
          check(ras_n && cas_n, "R8 strobes high at done", {ras_n, cas_n}, 3);
          check(!p_done, "R8 done single cycle", p_done, 0);
        end
      end
      p_ras = ras_n; p_cas = cas_n; p_ready = ready; p_req = ref_req; p_done = ref_done;
    end
  end

  initial begin
    int f0, f1, d1, r0;
    repeat (5) @(posedge clk);
    #2 rst = 1'b0;
    while (!ready) @(negedge clk);
    check(falls == WAKE, "R3 wake pulse count", falls, WAKE);
    check(first_cas >= PAUSE, "R2 pause respected", first_cas, PAUSE);
    check(ready_rise >= PAUSE + WAKE * (LEAD + LOW + PRE), "R3 ready time",
          ready_rise, PAUSE + WAKE * (LEAD + LOW + PRE));
    check(!ref_req && !overrun, "R3 clean after init", {ref_req, overrun}, 0);

    allow = 1;
    gap_mode = 1;
    r0 = req_rises;
    while (req_rises < r0 + 6) @(negedge clk);
    repeat (20) @(negedge clk);
    check(done_cnt == 6, "R8 done per refresh", done_cnt, 6);
    check(falls == WAKE + 6, "R6 one pulse per refresh", falls, WAKE + 6);
    check(!overrun && ready, "R6 no overrun when served", {overrun, ready}, 1);

    gap_mode = 0;
    allow = 0;
    while (!overrun) @(negedge clk);
    f0 = falls;
    check(!ready, "R9 ready dropped", ready, 0);
    check(ref_req, "R9 request held", ref_req, 1);
    repeat (30) @(negedge clk);
    check(falls == f0, "R7 no pulse without grant", falls - f0, 0);
    check(overrun && !ready, "R9 overrun persists", {overrun, ready}, 2);

    allow = 1;
    f1 = falls;
    while (!ready) @(negedge clk);
    check(falls - f1 == WAKE, "R10 recovery pulses", falls - f1, WAKE);
    check(!overrun, "R10 overrun cleared", overrun, 0);
    d1 = done_cnt;
    repeat (3 * INTV) @(negedge clk);
    check(done_cnt - d1 >= 2, "R6 refresh resumes", done_cnt - d1, 2);
    check(ready && !overrun, "R10 stays ready", {ready, overrun}, 2);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule